// File: doc/BRIEF.md
# Search-Mode Envelope Qualifier

During fast winding the auxiliary track is read at high speed and turned into a one-bit envelope. This block takes that bit and decides whether the head sits on a labelled stretch, where the envelope stays high, or on blank tape, where the envelope stays low. A short glitch filter first removes envelope pulses that are too brief to be real. A qualification timer then counts auxiliary-block ticks since the last accepted envelope edge. A level that survives a set number of ticks without an edge raises the matching flag.

The timer counts block ticks, not clock cycles, so the qualification time scales with the tape speed. It therefore works across the whole range of search speeds. All three outputs are forced low outside search mode. Entering search starts the qualification again from zero. The surrounding controller drives the two-bit operating mode and a tick once per auxiliary block length. It reads the filtered envelope and the two flags.

Top module: `search_env_qualifier`

## Requirements
- R1: In search mode (`mode_i` = 2'b11), `env_o` equals the filtered envelope level, delayed by one register stage.
- R2: A change on `env_raw_i` reaches the filtered level only after the new value has been sampled on GLITCH_CYC consecutive clock edges. A shorter pulse has no effect on `env_o`.
- R3: While the filtered level is high, `label_o` rises one cycle after the edge that samples the QUAL_BLOCKS-th `blk_tick_i` since the last filtered edge.
- R4: While the filtered level is low, `blank_o` rises under the same tick rule as R3.
- R5: A filtered edge restarts the tick count. A tick sampled on the same edge as the filtered edge is not counted. Both flags are low from the cycle in which `env_o` shows the new level.
- R6: In the modes 2'b00, 2'b01 and 2'b10, `env_o`, `label_o` and `blank_o` are all low from the cycle after the mode is sampled.
- R7: After entering search mode, both flags stay low until QUAL_BLOCKS ticks have been counted inside search mode.
- R8: `label_o` and `blank_o` are never high together.
- R9: After reset all outputs are low, and the filtered level starts low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| mode_i | input | 2 | Operating mode; 2'b11 selects search |
| env_raw_i | input | 1 | Sliced envelope bit of the auxiliary track |
| blk_tick_i | input | 1 | One-cycle pulse per auxiliary block length |
| env_o | output | 1 | Filtered envelope, gated by search mode |
| label_o | output | 1 | Labelled region qualified |
| blank_o | output | 1 | Blank tape qualified |

## Verification
The glitch filter is swept with pulses from one cycle up to two cycles beyond GLITCH_CYC. This separates pulses that are rejected from pulses that are accepted exactly at the threshold. The tick sweep gives each level zero up to QUAL_BLOCKS+1 ticks after a fresh edge. It shows that a flag rises on the right tick and not one tick early, for both polarities. Further runs place a tick on the same edge as an envelope flip and step through each non-search mode while a flag is up. The first shows that the coincident tick is discarded. The second shows that the outputs are forced low and that qualification starts again after re-entry.

// File: rtl/env_qual_pkg.sv
package env_qual_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_NORMAL = 2'b01,
    MODE_TEST   = 2'b10,
    MODE_SEARCH = 2'b11
  } op_mode_e;

  // Only the search mode lets the detector drive its outputs.
  function automatic logic mode_enables(input logic [1:0] mode);
    return mode == MODE_SEARCH;
  endfunction

  // Saturating tick count toward the qualification limit.
  function automatic int unsigned step_count(input int unsigned cur,
                                             input int unsigned lim,
                                             input logic tick);
    if (tick && cur < lim) return cur + 1;
    return cur;
  endfunction

  function automatic logic count_done(input int unsigned cur,
                                      input int unsigned lim);
    return cur >= lim;
  endfunction

endpackage

// File: rtl/env_deglitch.sv
module env_deglitch #(
  parameter int unsigned GLITCH_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o,
  output logic flip_o
);

  logic lvl_q;

  generate
    if (GLITCH_CYC <= 1) begin : g_pass
      assign flip_o = (raw_i != lvl_q);
      always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= raw_i;
      end
    end else begin : g_count
      localparam int unsigned RUN_W = $clog2(GLITCH_CYC);
      logic [RUN_W-1:0] run_q;
      assign flip_o = (raw_i != lvl_q) && (run_q == RUN_W'(GLITCH_CYC - 1));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          lvl_q <= 1'b0;
          run_q <= '0;
        end else if (raw_i == lvl_q) begin
          run_q <= '0;
        end else if (flip_o) begin
          lvl_q <= raw_i;
          run_q <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  endgenerate

  assign level_o = lvl_q;

endmodule

// File: rtl/env_block_timer.sv
module env_block_timer #(
  parameter int unsigned QUAL_BLOCKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en_i,
  input  logic restart_i,
  input  logic tick_i,
  output logic done_o
);
  import env_qual_pkg::*;

  localparam int unsigned CNT_W = $clog2(QUAL_BLOCKS + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (!run_en_i || restart_i) cnt_q <= '0;
    else cnt_q <= CNT_W'(step_count(int'(cnt_q), QUAL_BLOCKS, tick_i));
  end

  assign done_o = count_done(int'(cnt_q), QUAL_BLOCKS);

endmodule

// File: rtl/env_flag_gate.sv
module env_flag_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic level_i,
  input  logic done_i,
  output logic env_o,
  output logic label_o,
  output logic blank_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      env_o   <= 1'b0;
      label_o <= 1'b0;
      blank_o <= 1'b0;
    end else begin
      env_o   <= enable_i & level_i;
      label_o <= enable_i & done_i &  level_i;
      blank_o <= enable_i & done_i & ~level_i;
    end
  end

endmodule

// File: rtl/search_env_qualifier.sv
module search_env_qualifier #(
  parameter int unsigned GLITCH_CYC  = 8,
  parameter int unsigned QUAL_BLOCKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       env_raw_i,
  input  logic       blk_tick_i,
  output logic       env_o,
  output logic       label_o,
  output logic       blank_o
);
  import env_qual_pkg::*;

  // Named internal events, visible to the bound checker.
  logic search_w;
  logic level_w;
  logic flip_w;
  logic done_w;

  assign search_w = mode_enables(mode_i);

  env_deglitch #(.GLITCH_CYC(GLITCH_CYC)) u_deglitch (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_i   (env_raw_i),
    .level_o (level_w),
    .flip_o  (flip_w)
  );

  env_block_timer #(.QUAL_BLOCKS(QUAL_BLOCKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en_i  (search_w),
    .restart_i (flip_w),
    .tick_i    (blk_tick_i),
    .done_o    (done_w)
  );

  env_flag_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (search_w),
    .level_i  (level_w),
    .done_i   (done_w),
    .env_o    (env_o),
    .label_o  (label_o),
    .blank_o  (blank_o)
  );

endmodule

// File: rtl/search_env_qualifier_chk.sv
module search_env_qualifier_chk (
  input logic clk,
  input logic rst_n,
  input logic env_raw_i,
  input logic env_o,
  input logic label_o,
  input logic blank_o,
  input logic search_w,
  input logic level_w,
  input logic flip_w
);

  AST_ENV_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    search_w |=> (env_o == $past(level_w))); // R1

  AST_FILTER_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_w) |-> (level_w == $past(env_raw_i))); // R2

  AST_LABEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    label_o |-> env_o); // R3

  AST_BLANK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    blank_o |-> !env_o); // R4

  AST_EDGE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    flip_w |=> ##1 (!label_o && !blank_o)); // R5

  AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !search_w |=> (!env_o && !label_o && !blank_o)); // R6

  AST_ENTRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (search_w && !$past(search_w)) |=> (!label_o && !blank_o)); // R7

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(label_o && blank_o)); // R8

endmodule

bind search_env_qualifier search_env_qualifier_chk u_chk (.*);

// File: tb/search_env_qualifier_test.sv
module search_env_qualifier_test;

  localparam int G = 3;
  localparam int Q = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       env_raw_i = 1'b0;
  logic       blk_tick_i = 1'b0;
  logic       env_o, label_o, blank_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string cur_req = "R1";

  // Requirement-level reference state.
  logic m_lvl = 1'b0;
  int   m_run = 0;
  int   m_ticks = 0;

  always #5 clk = ~clk;

  search_env_qualifier #(.GLITCH_CYC(G), .QUAL_BLOCKS(Q)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .env_raw_i  (env_raw_i),
    .blk_tick_i (blk_tick_i),
    .env_o      (env_o),
    .label_o    (label_o),
    .blank_o    (blank_o)
  );

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // One cycle: drive at the falling edge, predict, sample after the rising edge.
  task automatic cyc(input logic e, input logic t, input logic [1:0] m);
    logic srch, x_env, x_lbl, x_blk, flipped;
    env_raw_i  = e;
    blk_tick_i = t;
    mode_i     = m;
    srch  = (m == 2'b11);
    x_env = srch && m_lvl;
    x_lbl = srch && (m_ticks == Q) && m_lvl;
    x_blk = srch && (m_ticks == Q) && !m_lvl;
    flipped = 1'b0;
    if (e != m_lvl) begin
      m_run++;
      if (m_run >= G) begin
        m_lvl = e;
        m_run = 0;
        flipped = 1'b1;
      end
    end else begin
      m_run = 0;
    end
    if (!srch || flipped) m_ticks = 0;
    else if (t && m_ticks < Q) m_ticks++;
    @(posedge clk);
    #2;
    chk(cur_req, "env_o", env_o, x_env);
    chk(cur_req, "label_o", label_o, x_lbl);
    chk(cur_req, "blank_o", blank_o, x_blk);
    chk("R8", "label_o&blank_o", label_o & blank_o, 1'b0);
    @(negedge clk);
  endtask

  task automatic hold(input logic e, input logic t, input logic [1:0] m, input int n);
    for (int i = 0; i < n; i++) cyc(e, t, m);
  endtask

  // Give k ticks, each followed by two idle cycles.
  task automatic ticks(input logic e, input logic [1:0] m, input int k);
    for (int i = 0; i < k; i++) begin
      cyc(e, 1'b1, m);
      hold(e, 1'b0, m, 2);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R9: reset state
    chk("R9", "env_o", env_o, 1'b0);
    chk("R9", "label_o", label_o, 1'b0);
    chk("R9", "blank_o", blank_o, 1'b0);

    // R1: envelope passes through in search mode
    cur_req = "R1";
    hold(1'b0, 1'b0, 2'b11, 4);
    hold(1'b1, 1'b0, 2'b11, G + 3);
    hold(1'b0, 1'b0, 2'b11, G + 3);

    // R2: pulse-width sweep around the filter threshold, both polarities
    cur_req = "R2";
    for (int pol = 0; pol < 2; pol++) begin
      for (int w = 1; w <= G + 2; w++) begin
        hold(pol[0], 1'b0, 2'b11, G + 2);
        hold(!pol[0], 1'b0, 2'b11, w);
        hold(pol[0], 1'b0, 2'b11, G + 3);
      end
    end

    // R3 / R4: tick-count sweep after a fresh edge
    for (int lvl = 0; lvl < 2; lvl++) begin
      cur_req = (lvl == 1) ? "R3" : "R4";
      for (int k = 0; k <= Q + 1; k++) begin
        hold(!lvl[0], 1'b0, 2'b11, G + 1);
        hold(lvl[0], 1'b0, 2'b11, G + 1);
        ticks(lvl[0], 2'b11, k);
        hold(lvl[0], 1'b0, 2'b11, 3);
      end
    end

    // R5: edge coinciding with a tick, then requalify the other level
    cur_req = "R5";
    hold(1'b1, 1'b0, 2'b11, G + 1);
    ticks(1'b1, 2'b11, Q);
    hold(1'b0, 1'b0, 2'b11, G - 1);
    cyc(1'b0, 1'b1, 2'b11);
    hold(1'b0, 1'b0, 2'b11, 2);
    ticks(1'b0, 2'b11, Q);
    hold(1'b1, 1'b1, 2'b11, G + 4);

    // R6 then R7: each non-search mode while a flag is up, then re-entry
    for (int m = 0; m < 3; m++) begin
      cur_req = "R6";
      hold(1'b1, 1'b0, 2'b11, G + 1);
      ticks(1'b1, 2'b11, Q + 1);
      hold(1'b1, 1'b1, m[1:0], 3);
      hold(1'b0, 1'b1, m[1:0], G + 2);
      hold(1'b1, 1'b1, m[1:0], G + 2);
      cur_req = "R7";
      hold(1'b1, 1'b0, 2'b11, 2);
      ticks(1'b1, 2'b11, Q + 1);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule